// File: doc/BRIEF.md
# Register-Controlled Sample Clock Generator

This block is the acquisition control core of a 16-channel logic analyzer. A byte-wide register bus with a single write strobe and a read strobe sets a channel-enable mask, a sample-clock divide ratio and a choice between two base-clock enables. A control and status register steps the block through a fixed sequence: arm, latch the configuration, start and stop. Each step changes the value that register reads back.

While the block is running, it produces a single-cycle sample strobe once every N+1 pulses of the selected base-clock enable. N is the value held in the divide register. A capture engine elsewhere uses the strobe and the channel mask to store samples. At all other times the strobe stays low.

Top module: `sclk_ctrl_core`

## Requirements
- R1: After reset, register 1 reads 0x08, register 0 reads 0x10, the strobe is low and the mask output is zero. Writes to register 0 leave it reading 0x10.
- R2: A read strobe returns data on `bus_rdata` with `bus_rvalid` high in the next cycle only. A read of any address other than 0, 1, 2, 3, 4 or 10 returns 0x00.
- R3: Register 2 holds channels 7..0 and register 3 holds channels 15..8 of the mask. Both read back as written and drive `chan_mask`.
- R4: Bit 0 of register 10 reads back as written, with bits 7..1 reading zero. A 0 selects `base_en0` and a 1 selects `base_en1` as the count source.
- R5: With value N in register 4, the running strobe is high for one cycle every N+1 selected enable pulses, for N from 0 to 255.
- R6: From idle, writing 0x40 to register 1 makes it read 0x40. Writing 0x42 next makes it read 0x42. Writing 0x40 after that latches the configuration, and register 1 then reads 0x48.
- R7: Writing 0x41 while register 1 reads 0x48 starts sampling. Register 1 then reads 0x49, and the first strobe follows N+1 enable pulses after the write.
- R8: Writing 0x00 to register 1 from any state returns it to idle (reads 0x08), and the strobe stays low from then on.
- R9: A control write that does not fit the current step leaves register 1 unchanged. Examples are 0x41 from idle or from the 0x40 step.
- R10: A write to register 4 or register 10 restarts the divider count, so the next strobe comes N+1 pulses after that write.
- R11: The strobe is low in every cycle that follows a cycle in which the block was not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en0 | input | 1 | Enable pulse of base clock 0 |
| base_en1 | input | 1 | Enable pulse of base clock 1 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the read strobe |
| bus_rvalid | output | 1 | High in the cycle that `bus_rdata` is valid |
| chan_mask | output | 16 | Channel-enable mask |
| sample_stb | output | 1 | Sample strobe |

## Verification
The assertions check the following on every cycle:
- the one-cycle read latency, the version and unmapped read values, and the mask readback;
- the stop, latch and start steps of the control register, and that the register holds its value when no control write occurs;
- that a strobe appears only after a running cycle, that a divider reload clears the count, and that the count never exceeds the ratio.

Only the bench scenarios can show the exact spacing of strobes for each ratio and each base source, the latency from the start write to the first strobe, and the phase restart after a divide write. The same applies to control writes that are ignored because they are out of sequence.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PEND,
        ST_LATCHED,
        ST_RUN
    } seq_state_e;

    // register addresses (fixed by the software sequence)
    localparam int A_VER   = 0;
    localparam int A_CTRL  = 1;
    localparam int A_MASK0 = 2;
    localparam int A_DIV   = 4;
    localparam int A_SEL   = 10;

    // control codes written to the control register
    localparam logic [7:0] CTRL_STOP  = 8'h00;
    localparam logic [7:0] CTRL_ARM   = 8'h40;
    localparam logic [7:0] CTRL_GO    = 8'h41;
    localparam logic [7:0] CTRL_LATCH = 8'h42;

    // status bit positions
    localparam int SB_RUN   = 0;
    localparam int SB_LATCH = 1;
    localparam int SB_READY = 3;
    localparam int SB_ARM   = 6;

endpackage

// File: rtl/sclk_seq.sv
module sclk_seq
    import sclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] status_o,
    output logic       run_o
);

    typedef struct packed {
        seq_state_e st;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr_i) begin
            if (wdata_i == CTRL_STOP) begin
                nxt_d.st = ST_IDLE;
            end else begin
                case (cur_q.st)
                    ST_IDLE:    if (wdata_i == CTRL_ARM) nxt_d.st = ST_ARMED;
                    ST_ARMED:   if (wdata_i == CTRL_LATCH) nxt_d.st = ST_PEND;
                    ST_PEND:    if (wdata_i == CTRL_ARM) nxt_d.st = ST_LATCHED;
                    ST_LATCHED: begin
                        if (wdata_i == CTRL_LATCH)   nxt_d.st = ST_PEND;
                        else if (wdata_i == CTRL_GO) nxt_d.st = ST_RUN;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE};
        else        cur_q <= nxt_d;
    end

    always_comb begin
        status_o           = 8'h00;
        status_o[SB_ARM]   = (cur_q.st != ST_IDLE);
        status_o[SB_READY] = (cur_q.st == ST_IDLE) || (cur_q.st == ST_LATCHED)
                           || (cur_q.st == ST_RUN);
        status_o[SB_LATCH] = (cur_q.st == ST_PEND);
        status_o[SB_RUN]   = (cur_q.st == ST_RUN);
    end

    assign run_o = (cur_q.st == ST_RUN);

    // R8: stop always returns to idle
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i == CTRL_STOP) |=> (status_o == 8'h08));

    // R6: second arm write after the latch code gives the latched status
    p_latch_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i == CTRL_ARM && status_o == 8'h42) |=> (status_o == 8'h48));

    // R7: go from the latched status starts running
    p_go_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i == CTRL_GO && status_o == 8'h48) |=> (run_o && status_o == 8'h49));

    // R9: without a control write the status does not move
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(status_o));

endmodule

// File: rtl/sclk_div.sv
module sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick0_i,
    input  logic             tick1_i,
    input  logic             sel_i,
    input  logic [DIV_W-1:0] ratio_i,
    input  logic             reload_i,
    input  logic             run_i,
    output logic             stb_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             stb;
    } div_t;

    div_t cur_q, nxt_d;
    logic tick;

    always_comb begin
        tick      = sel_i ? tick1_i : tick0_i;
        nxt_d     = cur_q;
        nxt_d.stb = 1'b0;
        if (reload_i || !run_i) begin
            nxt_d.cnt = '0;
        end else if (tick) begin
            if (cur_q.cnt == ratio_i) begin
                nxt_d.cnt = '0;
                nxt_d.stb = 1'b1;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign stb_o = cur_q.stb;

    // R11: a strobe only follows a running cycle
    p_stb_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> $past(run_i));

    // R10: a reload clears the phase
    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (cur_q.cnt == '0));

    // R5: the count never passes the ratio
    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= ratio_i);

endmodule

// File: rtl/sclk_ctrl_core.sv
module sclk_ctrl_core
    import sclk_pkg::*;
#(
    parameter int         ADDR_W  = 4,
    parameter int         DIV_W   = 8,
    parameter int         CHAN_N  = 16,
    parameter logic [7:0] VERSION = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_en0,
    input  logic              base_en1,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid,
    output logic [CHAN_N-1:0] chan_mask,
    output logic              sample_stb
);

    localparam int MASK_BYTES = CHAN_N / 8;
    localparam logic [ADDR_W-1:0] AD_VER  = ADDR_W'(A_VER);
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_DIV  = ADDR_W'(A_DIV);
    localparam logic [ADDR_W-1:0] AD_SEL  = ADDR_W'(A_SEL);

    typedef struct packed {
        logic [CHAN_N-1:0] mask;
        logic [DIV_W-1:0]  ratio;
        logic              sel;
        logic [7:0]        rdata;
        logic              rvalid;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic [7:0] status;
    logic [7:0] rd_val;
    logic       run;
    logic       ctrl_wr;
    logic       reload;

    assign ctrl_wr = bus_wr && (bus_addr == AD_CTRL);
    assign reload  = bus_wr && ((bus_addr == AD_DIV) || (bus_addr == AD_SEL));

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.rvalid = bus_rd;
        rd_val       = 8'h00;
        if (bus_wr) begin
            for (int b = 0; b < MASK_BYTES; b++) begin
                if (bus_addr == ADDR_W'(A_MASK0 + b)) nxt_d.mask[b*8 +: 8] = bus_wdata;
            end
            if (bus_addr == AD_DIV) nxt_d.ratio = bus_wdata[DIV_W-1:0];
            if (bus_addr == AD_SEL) nxt_d.sel   = bus_wdata[0];
        end
        if (bus_addr == AD_VER)  rd_val = VERSION;
        if (bus_addr == AD_CTRL) rd_val = status;
        for (int b = 0; b < MASK_BYTES; b++) begin
            if (bus_addr == ADDR_W'(A_MASK0 + b)) rd_val = cur_q.mask[b*8 +: 8];
        end
        if (bus_addr == AD_DIV) rd_val = 8'(cur_q.ratio);
        if (bus_addr == AD_SEL) rd_val = {7'b0, cur_q.sel};
        if (bus_rd) nxt_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign bus_rdata  = cur_q.rdata;
    assign bus_rvalid = cur_q.rvalid;
    assign chan_mask  = cur_q.mask;

    sclk_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ctrl_wr),
        .wdata_i  (bus_wdata),
        .status_o (status),
        .run_o    (run)
    );

    sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick0_i  (base_en0),
        .tick1_i  (base_en1),
        .sel_i    (cur_q.sel),
        .ratio_i  (cur_q.ratio),
        .reload_i (reload),
        .run_i    (run),
        .stb_o    (sample_stb)
    );

    // R2: read data valid exactly one cycle after the strobe
    p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R2: unmapped upper addresses read zero
    p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > AD_SEL) |=> (bus_rdata == 8'h00));

    // R1: version register is constant
    p_version_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == AD_VER) |=> (bus_rdata == VERSION));

    // R3: low mask byte follows its write
    p_mask_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_MASK0)) |=> (chan_mask[7:0] == $past(bus_wdata)));

endmodule

// File: tb/sim_sclk_ctrl_core.sv
module sim_sclk_ctrl_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_en0 = 1'b1;
    logic        base_en1 = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [15:0] chan_mask;
    logic        sample_stb;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;
    always @(negedge clk) base_en1 <= ~base_en1;

    sclk_ctrl_core u0 (
        .clk(clk), .rst_n(rst_n), .base_en0(base_en0), .base_en1(base_en1),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .chan_mask(chan_mask),
        .sample_stb(sample_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'(a);
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rvalid == 1'b1 && int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
    endtask

    task automatic start_run(input int n, input int s);
        wr(1, 8'h00);
        wr(4, n);
        wr(10, s);
        wr(1, 8'h40);
        wr(1, 8'h42);
        wr(1, 8'h40);
        wr(1, 8'h41);
    endtask

    // checks the next two strobe-to-strobe spacings
    task automatic measure(input int exp, input string req);
        int w = 0;
        while (!sample_stb && w < 3000) begin
            @(negedge clk);
            w++;
        end
        for (int rep = 0; rep < 2; rep++) begin
            int cnt = 0;
            do begin
                @(negedge clk);
                cnt++;
            end while (!sample_stb && cnt < 3000);
            chk(cnt == exp, req, cnt, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R5 actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(sample_stb == 1'b0, "R1 stb", int'(sample_stb), 0);
        chk(chan_mask == 16'h0, "R1 mask", int'(chan_mask), 0);
        chk(bus_rvalid == 1'b0, "R2 rvalid idle", int'(bus_rvalid), 0);
        rd_chk(1, 8'h08, "R1 idle status");
        rd_chk(0, 8'h10, "R1 version");
        wr(0, 8'h55);
        rd_chk(0, 8'h10, "R1 version after write");
        @(negedge clk);
        chk(bus_rvalid == 1'b0, "R2 rvalid one cycle", int'(bus_rvalid), 0);

        // R2 unmapped addresses
        for (int a = 5; a < 16; a++) begin
            if (a != 10) rd_chk(a, 0, "R2 unmapped");
        end

        // R3 mask patterns
        begin
            int pats[3] = '{16'h3CA5, 16'hFF00, 16'h0181};
            foreach (pats[i]) begin
                wr(2, pats[i] & 8'hFF);
                wr(3, pats[i] >> 8);
                rd_chk(2, pats[i] & 8'hFF, "R3 mask lo");
                rd_chk(3, pats[i] >> 8, "R3 mask hi");
                chk(int'(chan_mask) == pats[i], "R3 mask out", int'(chan_mask), pats[i]);
            end
        end

        // R4 select readback
        wr(10, 1);
        rd_chk(10, 1, "R4 sel one");
        wr(10, 0);
        rd_chk(10, 0, "R4 sel zero");
        wr(4, 8'h9C);
        rd_chk(4, 8'h9C, "R5 div readback");

        // R9 out-of-sequence go from idle
        wr(1, 8'h41);
        rd_chk(1, 8'h08, "R9 go from idle");
        begin
            int hi = 0;
            repeat (20) begin
                @(negedge clk);
                if (sample_stb) hi++;
            end
            chk(hi == 0, "R11 no strobe idle", hi, 0);
        end

        // R6 arm / latch sequence, R9 go while armed
        wr(1, 8'h40);
        rd_chk(1, 8'h40, "R6 armed");
        wr(1, 8'h41);
        rd_chk(1, 8'h40, "R9 go while armed");
        wr(1, 8'h42);
        rd_chk(1, 8'h42, "R6 latch pending");
        wr(1, 8'h40);
        rd_chk(1, 8'h48, "R6 latched");
        wr(1, 8'h00);
        rd_chk(1, 8'h08, "R8 stop from latched");

        // R7 start latency with N=5 on source 0
        start_run(5, 0);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk(sample_stb == (k == 6), "R7 first strobe", int'(sample_stb), int'(k == 6));
        end
        rd_chk(1, 8'h49, "R7 running status");

        // R8 / R11 stop
        wr(1, 8'h00);
        begin
            int hi = 0;
            repeat (30) begin
                @(negedge clk);
                if (sample_stb) hi++;
            end
            chk(hi == 0, "R8 strobe stopped", hi, 0);
        end
        rd_chk(1, 8'h08, "R8 idle after stop");

        // R10 phase restart on divide write
        start_run(7, 0);
        repeat (13) @(negedge clk);
        wr(4, 7);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk(sample_stb == (k == 8), "R10 restart", int'(sample_stb), int'(k == 8));
        end

        // R5 / R4 ratio sweep on both sources
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 17; n++) begin
                int nv = (n == 16) ? 255 : n;
                start_run(nv, s);
                measure((nv + 1) * (s + 1), s ? "R4 R5 source 1 spacing" : "R5 source 0 spacing");
            end
        end
        wr(1, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule